// File: doc/BRIEF.md
# Display Event Interrupt Collector

This block sits between the display timing logic of a two-panel controller and the processor's interrupt input. Three kinds of timing event (frame start, vertical sync start and vertical sync end) arrive as one-cycle pulses. Each pulse carries a one-bit tag that names the panel that produced it: 0 for the main panel, 1 for the sub panel. The block records each event in a sticky flag and combines the flags with per-event enable bits into one level-sensitive interrupt request.

Software reaches the block through a small word-addressed register bus with a one-cycle read latency. The control word holds the sticky flags and the enables side by side. A flag is acknowledged by writing 0 to its position, and writing 1 there leaves it unchanged, so a handler can write back the word it read with only the handled flags cleared. A second, read-only word tells which panel produced the most recent event.

Top module: `disp_irq_unit`

## Requirements
- R1: After reset the control word (word address 0) and the source word (word address 1) both read 0, and `irq` is low.
- R2: A pulse on `evt_vend`, `evt_vstart` or `evt_fstart` sets the sticky flag at control bit 0, 1 or 2 respectively on the next clock edge, whatever the enables hold.
- R3: A write to the control word clears each flag whose data bit (0 to 2) is 0 and leaves unchanged each flag whose data bit is 1. No write can set a flag.
- R4: A write to the control word loads bits 10:8 into the enables for frame start (bit 10), vertical sync start (bit 9) and vertical sync end (bit 8). All other control bits read 0, and a read of an unmapped word address returns 0.
- R5: `irq` is high exactly while at least one flag is set together with its paired enable (bit 2 with bit 10, bit 1 with bit 9, bit 0 with bit 8).
- R6: When an event pulse and a clearing write reach the same flag in the same cycle, the flag ends up set.
- R7: Source word bit 10 takes the value of `evt_chan` in every cycle in which any event pulse is present (1 for sub panel, 0 for main panel) and holds its value in all other cycles.
- R8: Writes to the source word have no effect on it or on the control word.
- R9: Several event pulses in the same cycle set all of their flags together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_rd | input | 1 | Read strobe; data appears on `bus_rdata` after the next edge |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data |
| evt_fstart | input | 1 | Frame start pulse |
| evt_vstart | input | 1 | Vertical sync start pulse |
| evt_vend | input | 1 | Vertical sync end pulse |
| evt_chan | input | 1 | Panel tag of the pulses in this cycle (1 = sub) |
| irq | output | 1 | Level interrupt request |

## Verification
The two functions that can collide in one cycle are latching a new event and acknowledging flags through a control-word write. The bench drives a write that clears every flag, and a vertical sync start pulse, in the same cycle. It then reads the control word back and expects bit 1 still set while the enables take the written value. Separately, it drives a write to the source word in a cycle without an event, and confirms that the panel indicator and the flags are unchanged.

// File: rtl/disp_irq_pkg.sv
package disp_irq_pkg;
   localparam int EVT_COUNT = 3;

   // flag positions in the control word; the enable for a flag sits ENA_LSB above it
   typedef enum int {
      EV_VEND   = 0,
      EV_VSTART = 1,
      EV_FSTART = 2
   } evt_idx_e;

   function automatic int ena_pos(input int ena_lsb, input evt_idx_e ev);
      return ena_lsb + int'(ev);
   endfunction
endpackage

// File: rtl/disp_irq_flags.sv
module disp_irq_flags #(
   parameter int N_EVT   = 3,
   parameter int DATA_W  = 32,
   parameter int ENA_LSB = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_EVT-1:0]  evt_i,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [N_EVT-1:0]  stat_o,
   output logic [N_EVT-1:0]  ena_o,
   output logic              irq_o
);
   if (ENA_LSB < N_EVT || ENA_LSB + N_EVT > DATA_W) begin : g_bad_layout
      $error("disp_irq_flags: enable field overlaps flags or exceeds data width");
   end

   for (genvar i = 0; i < N_EVT; i++) begin : g_bit
      logic stat_q;
      logic ena_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stat_q <= 1'b0;
            ena_q  <= 1'b0;
         end else begin
            if (evt_i[i])
               stat_q <= 1'b1;
            else if (wr_i && !wdata_i[i])
               stat_q <= 1'b0;
            if (wr_i)
               ena_q <= wdata_i[ENA_LSB+i];
         end
      end

      assign stat_o[i] = stat_q;
      assign ena_o[i]  = ena_q;

      AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
         evt_i[i] |=> stat_q); // R2
      AST_EVT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
         (evt_i[i] && wr_i && !wdata_i[i]) |=> stat_q); // R6
      AST_NO_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
         (!stat_q && !evt_i[i]) |=> !stat_q); // R3
      AST_ENA_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
         wr_i |=> (ena_q == $past(wdata_i[ENA_LSB+i]))); // R4
   end

   assign irq_o = |(stat_o & ena_o);
endmodule

// File: rtl/disp_irq_src.sv
module disp_irq_src #(
   parameter int N_EVT = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_EVT-1:0] evt_i,
   input  logic             chan_i,
   output logic             sub_o
);
   logic sub_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sub_q <= 1'b0;
      else if (|evt_i)
         sub_q <= chan_i;
   end

   assign sub_o = sub_q;

   AST_SRC_TAKES_TAG: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt_i) |=> (sub_q == $past(chan_i))); // R7
   AST_SRC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_i == '0) |=> $stable(sub_q)); // R7
endmodule

// File: rtl/disp_irq_regif.sv
module disp_irq_regif #(
   parameter int N_EVT     = 3,
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 4,
   parameter int ENA_LSB   = 8,
   parameter int SRC_BIT   = 10,
   parameter int CTRL_ADDR = 0,
   parameter int SRC_ADDR  = 1,
   parameter bit RD_REG    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [N_EVT-1:0]  stat_i,
   input  logic [N_EVT-1:0]  ena_i,
   input  logic              sub_i,
   output logic              ctrl_wr_o,
   output logic [DATA_W-1:0] rdata_o
);
   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
   localparam logic [ADDR_W-1:0] SRC_A  = ADDR_W'(SRC_ADDR);

   if (CTRL_ADDR == SRC_ADDR) begin : g_bad_map
      $error("disp_irq_regif: both words share one address");
   end
   if (SRC_BIT >= DATA_W) begin : g_bad_src
      $error("disp_irq_regif: source bit outside data word");
   end

   logic              hit_ctrl;
   logic              hit_src;
   logic [DATA_W-1:0] ctrl_word;
   logic [DATA_W-1:0] src_word;
   logic [DATA_W-1:0] rd_next;

   assign hit_ctrl  = (bus_addr == CTRL_A);
   assign hit_src   = (bus_addr == SRC_A);
   assign ctrl_wr_o = bus_wr && hit_ctrl;

   always_comb begin
      ctrl_word                    = '0;
      ctrl_word[N_EVT-1:0]         = stat_i;
      ctrl_word[ENA_LSB +: N_EVT]  = ena_i;
      src_word                     = '0;
      src_word[SRC_BIT]            = sub_i;
      if (hit_ctrl)
         rd_next = ctrl_word;
      else if (hit_src)
         rd_next = src_word;
      else
         rd_next = '0;
   end

   if (RD_REG) begin : g_rd_flop
      logic [DATA_W-1:0] rdata_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            rdata_q <= '0;
         else if (bus_rd)
            rdata_q <= rd_next;
      end
      assign rdata_o = rdata_q;

      if (ENA_LSB > N_EVT) begin : g_gap_chk
         AST_GAP_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_rd && hit_ctrl) |=> (rdata_o[ENA_LSB-1:N_EVT] == '0)); // R4
      end
   end else begin : g_rd_comb
      assign rdata_o = rd_next;
   end
endmodule

// File: rtl/disp_irq_unit.sv
module disp_irq_unit
   import disp_irq_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 4,
   parameter int ENA_LSB   = 8,
   parameter int SRC_BIT   = 10,
   parameter int CTRL_ADDR = 0,
   parameter int SRC_ADDR  = 1,
   parameter bit RD_REG    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              evt_fstart,
   input  logic              evt_vstart,
   input  logic              evt_vend,
   input  logic              evt_chan,
   output logic              irq
);
   localparam int N_EVT = EVT_COUNT;
   localparam logic [ADDR_W-1:0] SRC_A = ADDR_W'(SRC_ADDR);

   logic [N_EVT-1:0] evt_vec;
   logic [N_EVT-1:0] stat;
   logic [N_EVT-1:0] ena;
   logic             sub_flag;
   logic             ctrl_wr;

   always_comb begin
      evt_vec                  = '0;
      evt_vec[int'(EV_VEND)]   = evt_vend;
      evt_vec[int'(EV_VSTART)] = evt_vstart;
      evt_vec[int'(EV_FSTART)] = evt_fstart;
   end

   disp_irq_regif #(
      .N_EVT(N_EVT), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .ENA_LSB(ENA_LSB),
      .SRC_BIT(SRC_BIT), .CTRL_ADDR(CTRL_ADDR), .SRC_ADDR(SRC_ADDR), .RD_REG(RD_REG)
   ) u_regif (
      .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .stat_i(stat), .ena_i(ena), .sub_i(sub_flag),
      .ctrl_wr_o(ctrl_wr), .rdata_o(bus_rdata)
   );

   disp_irq_flags #(
      .N_EVT(N_EVT), .DATA_W(DATA_W), .ENA_LSB(ENA_LSB)
   ) u_flags (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_vec), .wr_i(ctrl_wr), .wdata_i(bus_wdata),
      .stat_o(stat), .ena_o(ena), .irq_o(irq)
   );

   disp_irq_src #(
      .N_EVT(N_EVT)
   ) u_src (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_vec), .chan_i(evt_chan), .sub_o(sub_flag)
   );

   AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (|stat)); // R5
   AST_IRQ_NEEDS_ENA: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (|ena)); // R5
   AST_SRC_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == SRC_A && evt_vec == '0) |=> ($stable(sub_flag) && $stable(stat))); // R8
endmodule

// File: tb/disp_irq_unit_test.sv
module disp_irq_unit_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        bus_rd, bus_wr;
   logic [3:0]  bus_addr;
   logic [31:0] bus_wdata;
   logic [31:0] bus_rdata;
   logic        evt_fstart, evt_vstart, evt_vend, evt_chan;
   logic        irq;

   always #(CLK_PERIOD/2) clk = ~clk;

   disp_irq_unit uut (
      .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_fstart(evt_fstart),
      .evt_vstart(evt_vstart), .evt_vend(evt_vend), .evt_chan(evt_chan), .irq(irq)
   );

   typedef struct {
      logic [31:0] data;
      logic        irq;
      string       tag;
   } exp_t;

   exp_t scb[$];
   int   vectors     = 0;
   int   miscompares = 0;
   logic [2:0] m_stat = '0;
   logic [2:0] m_ena  = '0;
   logic       m_sub  = 1'b0;

   task automatic idle_inputs();
      bus_rd = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
      evt_fstart = 1'b0; evt_vstart = 1'b0; evt_vend = 1'b0; evt_chan = 1'b0;
   endtask

   // ev = {frame start, vsync start, vsync end}
   task automatic step(input logic wr, input logic [3:0] addr, input logic [31:0] wd,
                       input logic [2:0] ev, input logic ch);
      @(negedge clk);
      bus_wr = wr; bus_addr = addr; bus_wdata = wd; bus_rd = 1'b0;
      {evt_fstart, evt_vstart, evt_vend} = ev; evt_chan = ch;
      @(posedge clk);
      if (wr && addr == 4'd0) begin
         m_stat = (m_stat & wd[2:0]) | ev;
         m_ena  = wd[10:8];
      end else begin
         m_stat = m_stat | ev;
      end
      if (|ev) m_sub = ch;
      @(negedge clk);
      idle_inputs();
   endtask

   task automatic rd(input logic [3:0] addr, input string tag);
      exp_t e;
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = addr;
      if (addr == 4'd0)      e.data = {21'd0, m_ena, 5'd0, m_stat};
      else if (addr == 4'd1) e.data = {21'd0, m_sub, 10'd0};
      else                   e.data = '0;
      e.irq = |(m_stat & m_ena);
      e.tag = tag;
      scb.push_back(e);
      @(posedge clk);
      @(negedge clk);
      idle_inputs();
   endtask

   // monitor: read data is registered, compare a quarter period after the capturing edge
   always @(posedge clk) begin
      if (rst_n && bus_rd) begin
         #(CLK_PERIOD/4);
         if (scb.size() == 0) begin
            miscompares++;
            $display("FAIL scoreboard: actual=unexpected read expected=none");
         end else begin
            exp_t e;
            e = scb.pop_front();
            vectors++;
            if (bus_rdata !== e.data || irq !== e.irq) begin
               miscompares++;
               $display("FAIL %s: actual rdata=%h irq=%b expected rdata=%h irq=%b",
                        e.tag, bus_rdata, irq, e.data, e.irq);
            end
         end
      end
   end

   initial begin
      #(CLK_PERIOD*20000);
      miscompares++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      idle_inputs();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      rd(4'd0, "R1 control after reset");
      rd(4'd1, "R1 source after reset");
      rd(4'd7, "R4 unmapped reads zero");

      step(1'b0, 4'd0, 32'h0, 3'b001, 1'b0);
      rd(4'd0, "R2 vsync end latched while disabled, R5 no irq");

      step(1'b1, 4'd0, 32'h0000_0101, 3'b000, 1'b0);
      rd(4'd0, "R4 enable loads, R5 irq with paired enable");

      step(1'b1, 4'd0, 32'hFFFF_FFFF, 3'b000, 1'b0);
      rd(4'd0, "R3 ones do not set, R4 other bits zero");

      step(1'b1, 4'd0, 32'h0000_0700, 3'b000, 1'b0);
      rd(4'd0, "R3 zero clears flag");

      step(1'b0, 4'd0, 32'h0, 3'b111, 1'b1);
      rd(4'd0, "R9 simultaneous events");
      rd(4'd1, "R7 sub tag recorded");

      step(1'b0, 4'd0, 32'h0, 3'b100, 1'b0);
      rd(4'd1, "R7 main tag recorded");

      step(1'b0, 4'd0, 32'h0, 3'b010, 1'b1);
      step(1'b0, 4'd0, 32'h0, 3'b000, 1'b0);
      rd(4'd1, "R7 tag held without events");

      step(1'b1, 4'd1, 32'h0, 3'b000, 1'b0);
      rd(4'd1, "R8 source write ignored");
      step(1'b1, 4'd1, 32'hFFFF_FFFF, 3'b000, 1'b0);
      rd(4'd0, "R8 control untouched by source write");

      step(1'b1, 4'd0, 32'h0, 3'b010, 1'b0);
      rd(4'd0, "R6 event beats same-cycle clear");
      rd(4'd1, "R7 tag from collision cycle");

      step(1'b1, 4'd0, 32'h0000_0402, 3'b000, 1'b0);
      rd(4'd0, "R5 unpaired enable gives no irq");
      step(1'b1, 4'd0, 32'h0000_0202, 3'b000, 1'b0);
      rd(4'd0, "R5 paired enable raises irq");
      step(1'b1, 4'd0, 32'h0000_0200, 3'b000, 1'b0);
      rd(4'd0, "R3 acknowledge drops irq");

      repeat (3) @(negedge clk);
      if (scb.size() != 0) begin
         miscompares++;
         $display("FAIL scoreboard: actual=%0d pending expected=0", scb.size());
      end
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule